// File: doc/BRIEF.md
# RTC Alarm and Interrupt Unit

This unit sits beside a real-time clock time base and raises alarms from it. The time base supplies the current seconds count, the current millisecond count and a strobe that pulses once per millisecond. Software programs the unit through a simple write port and a combinational read port. It has two seconds-compare alarms, one millisecond-compare alarm and one millisecond countdown.

Each alarm source sets its own sticky flag in a five-bit status register. Software clears a flag by writing a one to it. A five-bit mask register selects which flags drive the single interrupt line. The flag bit positions are the same in the status and mask registers. Register offsets and bit positions are fixed, because the software that services the interrupt decodes them.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Byte offsets and readback widths:
  - 0x14: seconds alarm A, 32 bits.
  - 0x18: seconds alarm B, 32 bits.
  - 0x1C: millisecond alarm, bits 9:0 only.
  - 0x24: countdown, with the arm bit at 31 and the count in bits 27:0.
  - 0x28: mask, bits 4:0.
  - 0x2C: status, bits 4:0.
  - All other bits, and any other offset, read 0.
- R3: The status and mask bits are assigned as follows: bit 0 is seconds alarm A, bit 1 is seconds alarm B, bit 2 is the millisecond alarm and bit 4 is the countdown. Bit 3 is kept for a seconds countdown and never sets.
- R4: A seconds alarm sets its status bit at the clock edge where `sec_i` first equals the alarm value. It sets once per entry into that equality. Holding the value does not set it again after a clear, but leaving and re-entering does.
- R5: A seconds alarm whose value is 0 is disabled and never sets its status bit.
- R6: The millisecond alarm sets status bit 2 on a clock edge where `ms_tick_i` is high and `msec_i` equals its value.
- R7: Countdown operation:
  - Writing with bit 31 set arms the countdown and loads the count. Writing with bit 31 clear (for example 0) disarms it.
  - While armed, each tick lowers the count by 1.
  - A tick at a count of 1 or 0 sets status bit 4 and leaves the register at 0, disarmed.
  - A register write in the same cycle as a tick takes priority over the tick.
- R8: Status bits are sticky and cleared by writing a 1 to them. Zero bits in the write data have no effect. An event in the same cycle as a clear of its bit leaves the bit set.
- R9: Status bits set whether or not they are masked.
- R10: `irq_o` is high exactly when some status bit and the matching mask bit are both 1. It follows a mask or status write in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_i | input | 32 | Current seconds from the time base |
| msec_i | input | 10 | Current milliseconds from the time base |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt, OR of status AND mask |

## Verification
The assertions assume the following about the inputs:
- `ms_tick_i` is a single-cycle strobe.
- `reg_addr_i` and `reg_wdata_i` are stable while `reg_we_i` is high.
- A countdown load cannot wrap below zero, because the register returns to 0 at a count of 1 or 0.

The stimulus changes inputs only on falling edges and holds each strobe for exactly one cycle. It steps `sec_i` through alarm values and away from them, so that the entry condition of R4 is exercised rather than a held level. It deliberately lines up a tick with a countdown write, and an event with a status clear, to reach the same-cycle priority rules in R7 and R8.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSRC   = 5;

  // byte offsets decoded by servicing software
  localparam logic [ADDR_W-1:0] OFF_SEC_A = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_SEC_B = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_MSCMP = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CDN   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h2C;

  // shared mask/status bit positions
  localparam int unsigned B_SEC_A = 0;
  localparam int unsigned B_SEC_B = 1;
  localparam int unsigned B_MSCMP = 2;
  localparam int unsigned B_SCDN  = 3;
  localparam int unsigned B_MSCDN = 4;

  localparam int unsigned CDN_ARM_BIT = 31;
endpackage

// File: rtl/rtc_sec_cmp.sv
module rtc_sec_cmp #(
  parameter int unsigned SW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wdata_i,
  input  logic [SW-1:0] sec_i,
  output logic [SW-1:0] val_o,
  output logic          evt_o
);
  logic [SW-1:0] val_q;
  logic          hit, hit_q;

  assign hit   = (val_q != '0) && (sec_i == val_q);
  assign evt_o = hit & ~hit_q;   // entry into match only
  assign val_o = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (we_i) val_q <= wdata_i;
    end
  end
endmodule

// File: rtl/rtc_ms_cmp.sv
module rtc_ms_cmp #(
  parameter int unsigned MW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [MW-1:0] wdata_i,
  input  logic [MW-1:0] msec_i,
  input  logic          tick_i,
  output logic [MW-1:0] val_o,
  output logic          evt_o
);
  logic [MW-1:0] val_q;

  assign evt_o = tick_i && (msec_i == val_q);
  assign val_o = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_q <= '0;
    else if (we_i) val_q <= wdata_i;
  end
endmodule

// File: rtl/rtc_cdn_timer.sv
module rtc_cdn_timer #(
  parameter int unsigned CW = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          warm_i,
  input  logic [CW-1:0] wcnt_i,
  input  logic          tick_i,
  output logic          en_o,
  output logic [CW-1:0] cnt_o,
  output logic          evt_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          en_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last  = (cnt_q <= ONE);
  assign evt_o = tick_i & en_q & ~we_i & last;  // write wins over tick
  assign en_o  = en_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (we_i) begin
      en_q  <= warm_i;
      cnt_q <= wcnt_i;
    end else if (tick_i && en_q) begin
      if (last) begin
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic         stat_we_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q, stat_q, clr;

  assign clr    = stat_we_i ? wdata_i : '0;
  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      stat_q <= (stat_q & ~clr) | evt_i;  // set beats clear
    end
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alm_pkg::*;
#(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned MS_W  = 10,
  parameter int unsigned CDN_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MS_W-1:0]   msec_i,
  input  logic              ms_tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned NSEC = 2;
  localparam logic [ADDR_W-1:0] SEC_OFF [NSEC] = '{OFF_SEC_A, OFF_SEC_B};

  logic [SEC_W-1:0] sec_val [NSEC];
  logic [NSEC-1:0]  sec_evt;
  logic [MS_W-1:0]  ms_val;
  logic             ms_evt, ms_we;
  logic             cdn_we, cdn_en, cdn_evt;
  logic [CDN_W-1:0] cdn_cnt;
  logic             mask_we, stat_we;
  logic [NSRC-1:0]  mask_q, stat_q, evt;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    logic we;
    assign we = reg_we_i && (reg_addr_i == SEC_OFF[g]);
    rtc_sec_cmp #(.SW(SEC_W)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .wdata_i (reg_wdata_i[SEC_W-1:0]),
      .sec_i   (sec_i),
      .val_o   (sec_val[g]),
      .evt_o   (sec_evt[g])
    );
  end

  assign ms_we = reg_we_i && (reg_addr_i == OFF_MSCMP);

  rtc_ms_cmp #(.MW(MS_W)) u_ms (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ms_we),
    .wdata_i (reg_wdata_i[MS_W-1:0]),
    .msec_i  (msec_i),
    .tick_i  (ms_tick_i),
    .val_o   (ms_val),
    .evt_o   (ms_evt)
  );

  assign cdn_we = reg_we_i && (reg_addr_i == OFF_CDN);

  rtc_cdn_timer #(.CW(CDN_W)) u_cdn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cdn_we),
    .warm_i  (reg_wdata_i[CDN_ARM_BIT]),
    .wcnt_i  (reg_wdata_i[CDN_W-1:0]),
    .tick_i  (ms_tick_i),
    .en_o    (cdn_en),
    .cnt_o   (cdn_cnt),
    .evt_o   (cdn_evt)
  );

  always_comb begin
    evt          = '0;
    evt[B_SEC_A] = sec_evt[0];
    evt[B_SEC_B] = sec_evt[1];
    evt[B_MSCMP] = ms_evt;
    evt[B_SCDN]  = 1'b0;
    evt[B_MSCDN] = cdn_evt;
  end

  assign mask_we = reg_we_i && (reg_addr_i == OFF_MASK);
  assign stat_we = reg_we_i && (reg_addr_i == OFF_STAT);

  rtc_irq_ctrl #(.N(NSRC)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (mask_we),
    .stat_we_i (stat_we),
    .wdata_i   (reg_wdata_i[NSRC-1:0]),
    .evt_i     (evt),
    .mask_o    (mask_q),
    .stat_o    (stat_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_SEC_A: reg_rdata_o = DATA_W'(sec_val[0]);
      OFF_SEC_B: reg_rdata_o = DATA_W'(sec_val[1]);
      OFF_MSCMP: reg_rdata_o = DATA_W'(ms_val);
      OFF_CDN: begin
        reg_rdata_o[CDN_W-1:0]   = cdn_cnt;
        reg_rdata_o[CDN_ARM_BIT] = cdn_en;
      end
      OFF_MASK:  reg_rdata_o = DATA_W'(mask_q);
      OFF_STAT:  reg_rdata_o = DATA_W'(stat_q);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_unit_chk.sv
module rtc_alarm_unit_chk #(
  parameter int unsigned SW = 32,
  parameter int unsigned CW = 28,
  parameter int unsigned N  = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          stat_we_i,
  input logic          cdn_we_i,
  input logic [N-1:0]  stat_i,
  input logic [N-1:0]  mask_i,
  input logic [SW-1:0] alm_a_i,
  input logic          cdn_en_i,
  input logic [CW-1:0] cdn_cnt_i,
  input logic          cdn_evt_i,
  input logic          irq_i
);
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i |=> ((stat_i & $past(stat_i)) == $past(stat_i)));  // R8

  AST_SEC_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[0]) |-> ($past(alm_a_i) != '0));  // R5

  AST_CDN_SELF_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdn_evt_i |=> (!cdn_en_i && cdn_cnt_i == '0));  // R7

  AST_CDN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdn_en_i && tick_i && !cdn_we_i && cdn_cnt_i > CW'(1))
      |=> (cdn_en_i && cdn_cnt_i == $past(cdn_cnt_i) - CW'(1)));  // R7

  AST_CDN_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[4]) |-> $past(cdn_en_i));  // R7

  AST_IRQ_NO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_i);  // R10

  AST_SCDN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_i[3]);  // R3
endmodule

bind rtc_alarm_unit rtc_alarm_unit_chk #(.SW(SEC_W), .CW(CDN_W), .N(5)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (ms_tick_i),
  .stat_we_i (stat_we),
  .cdn_we_i  (cdn_we),
  .stat_i    (stat_q),
  .mask_i    (mask_q),
  .alm_a_i   (sec_val[0]),
  .cdn_en_i  (cdn_en),
  .cdn_cnt_i (cdn_cnt),
  .cdn_evt_i (cdn_evt),
  .irq_i     (irq_o)
);

// File: tb/rtc_alarm_unit_tb.sv
`timescale 1ns/1ps
module rtc_alarm_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sec = '0;
  logic [9:0]  msec = '0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  rtc_alarm_unit u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sec_i       (sec),
    .msec_i      (msec),
    .ms_tick_i   (tick),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  typedef struct {
    logic [31:0] exp;
    logic        is_irq;
    string       tag;
  } item_t;

  item_t sb_q[$];
  item_t it;
  event  mon_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [31:0] got;

  // monitor: pops expected items and compares them to the outputs
  always @(mon_ev) begin
    while (sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      got = it.is_irq ? {31'b0, irq} : rdata;
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, got, it.exp);
      end
    end
  end

  task automatic push_exp(input logic [31:0] e, input logic i, input string tag);
    item_t x;
    x.exp = e; x.is_irq = i; x.tag = tag;
    sb_q.push_back(x);
    ->mon_ev;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    push_exp(e, 1'b0, tag);
  endtask

  task automatic irq_exp(input logic e, input string tag);
    @(negedge clk);
    #1;
    push_exp({31'b0, e}, 1'b1, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ms_tick(input logic [9:0] m);
    @(negedge clk);
    tick = 1'b1; msec = m;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d, input logic [9:0] m);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; tick = 1'b1; msec = m;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
  endtask

  task automatic set_sec(input logic [31:0] s);
    @(negedge clk);
    sec = s;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL timeout actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_exp(8'h14, 32'h0, "R1 sec A");
    rd_exp(8'h18, 32'h0, "R1 sec B");
    rd_exp(8'h1C, 32'h0, "R1 ms alarm");
    rd_exp(8'h24, 32'h0, "R1 countdown");
    rd_exp(8'h28, 32'h0, "R1 mask");
    rd_exp(8'h2C, 32'h0, "R1 status");
    irq_exp(1'b0, "R1 irq");

    // R2 offsets and readback widths
    wr(8'h14, 32'h0000_0100);
    wr(8'h18, 32'h0000_0200);
    wr(8'h1C, 32'hFFFF_F3E7);
    wr(8'h24, 32'h0000_0005);
    rd_exp(8'h14, 32'h0000_0100, "R2 sec A");
    rd_exp(8'h18, 32'h0000_0200, "R2 sec B");
    rd_exp(8'h1C, 32'h0000_03E7, "R2 ms alarm width");
    rd_exp(8'h24, 32'h0000_0005, "R2 countdown stored disarmed");
    ms_tick(10'd0);
    rd_exp(8'h24, 32'h0000_0005, "R7 disarmed no decrement");
    rd_exp(8'h30, 32'h0, "R2 unmapped");
    wr(8'h28, 32'hFFFF_FFFF);
    rd_exp(8'h28, 32'h0000_001F, "R3 mask width");
    wr(8'h28, 32'h0);

    // R5 zero alarm disabled
    wr(8'h18, 32'h0);
    set_sec(32'h200);
    set_sec(32'h0);
    rd_exp(8'h2C, 32'h0, "R5 zero alarm quiet");

    // R4 seconds match, R9 unmasked-independent, R10 masked no irq
    set_sec(32'h100);
    rd_exp(8'h2C, 32'h1, "R4 sec A fired");
    irq_exp(1'b0, "R10 masked no irq");
    wr(8'h2C, 32'h1);
    set_sec(32'h100);
    rd_exp(8'h2C, 32'h0, "R4 held match no refire");
    set_sec(32'h101);
    set_sec(32'h100);
    rd_exp(8'h2C, 32'h1, "R4 re-entry fires");

    // R8 sticky, W1C
    wr(8'h2C, 32'h0);
    rd_exp(8'h2C, 32'h1, "R8 write zero no effect");
    wr(8'h2C, 32'h1);
    rd_exp(8'h2C, 32'h0, "R8 w1c clears");

    // R6 millisecond compare
    ms_tick(10'd998);
    rd_exp(8'h2C, 32'h0, "R6 miss");
    @(negedge clk); msec = 10'd999;
    rd_exp(8'h2C, 32'h0, "R6 no tick no fire");
    ms_tick(10'd999);
    rd_exp(8'h2C, 32'h4, "R6 hit on tick");
    wr_tick(8'h2C, 32'h4, 10'd999);
    rd_exp(8'h2C, 32'h4, "R8 set beats clear");
    wr(8'h2C, 32'h1F);

    // R7 countdown
    wr(8'h24, 32'h8000_0003);
    rd_exp(8'h24, 32'h8000_0003, "R7 armed readback");
    ms_tick(10'd0);
    rd_exp(8'h24, 32'h8000_0002, "R7 step 1");
    ms_tick(10'd0);
    rd_exp(8'h24, 32'h8000_0001, "R7 step 2");
    rd_exp(8'h2C, 32'h0, "R7 not yet fired");
    ms_tick(10'd0);
    rd_exp(8'h24, 32'h0, "R7 self disarm");
    rd_exp(8'h2C, 32'h10, "R7 fired bit4");
    wr(8'h2C, 32'h10);
    wr(8'h24, 32'h8000_0002);
    wr(8'h24, 32'h0);
    ms_tick(10'd0);
    ms_tick(10'd0);
    rd_exp(8'h24, 32'h0, "R7 disarm by zero");
    rd_exp(8'h2C, 32'h0, "R7 disarmed no fire");
    wr(8'h24, 32'h8000_0001);
    wr_tick(8'h24, 32'h8000_0004, 10'd0);
    rd_exp(8'h24, 32'h8000_0004, "R7 write beats tick");
    rd_exp(8'h2C, 32'h0, "R7 write beats tick no fire");
    wr(8'h24, 32'h0);

    // R10 interrupt line
    wr(8'h24, 32'h8000_0001);
    ms_tick(10'd0);
    irq_exp(1'b0, "R10 mask zero");
    wr(8'h28, 32'h10);
    irq_exp(1'b1, "R10 unmasked asserts");
    wr(8'h28, 32'h0F);
    irq_exp(1'b0, "R10 other bits masked");
    wr(8'h28, 32'h10);
    wr(8'h2C, 32'h10);
    irq_exp(1'b0, "R10 cleared status");
    wr(8'h28, 32'h0);

    // R3 bit map, bit 3 never sets
    wr(8'h18, 32'h300);
    set_sec(32'h300);
    rd_exp(8'h2C, 32'h2, "R3 sec B bit1");
    ms_tick(10'd999);
    set_sec(32'h100);
    wr(8'h24, 32'h8000_0001);
    ms_tick(10'd0);
    rd_exp(8'h2C, 32'h17, "R3 all sources, bit3 clear");
    wr(8'h2C, 32'hFFFF_FFFF);
    rd_exp(8'h2C, 32'h0, "R8 clear all");

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule